// File: doc/BRIEF.md
# I2C Register Slave with Indexed Readback

This block is an I2C slave. It lets a host on the two-wire bus write 16-bit words into a bank of registers and read back 32-bit words from a set of sources. Every transaction begins with the slave address byte and its read/write bit. In a write-direction transaction the next byte is an 8-bit register pointer. After the pointer come up to two data bytes, high byte first. When the second data byte has been acknowledged, the block presents the pointer and the 16-bit word on a register-write port with a one-cycle strobe.

A read-direction transaction uses the pointer left by the most recent write-direction transaction. The host can send a pointer-only write followed by a STOP or a repeated START. The low seven bits of the pointer choose one of `NUM_SRC` 32-bit sources, and the chosen word goes out as four bytes, most significant byte first. A narrower value can be offered by padding it with zeros in the upper bits. The host ends the readout with a NACK, which may come before the fourth byte.

Both bus lines are brought into the system clock through two flip-flops. START and STOP are found from SDA edges while SCL is high. SDA is open-drain: `sda_oe` high means the block pulls SDA low.

Top module: `i2c_reg_slave`

## Requirements
- R1: A falling SDA edge while SCL is high (START) restarts byte reception at the slave address, including a repeated START within a transaction. A rising SDA edge while SCL is high (STOP) returns the block to idle, so bytes clocked after a STOP get no ACK.
- R2: A slave address byte whose upper seven bits equal `SLAVE_ADDR` is acknowledged by holding SDA low for the ninth clock. Bit 0 of that byte selects read (1) or write (0).
- R3: A slave address that does not match gets no ACK. The block then ignores all bus activity, including a matching address byte, until the next START, and it produces no write strobe.
- R4: In a write, the byte after the slave address is the register pointer, and the two bytes after it are data bits [15:8] and then [7:0]. When the ACK clock of the second data byte ends, `wr_stb` is high for exactly one system clock, with `wr_addr` equal to the pointer and `wr_data` equal to the word.
- R5: Each of the pointer and the two data bytes is acknowledged. A fourth byte after the slave address in a write gets no ACK.
- R6: A read returns source number `ptr[6:0]`. Pointer bit 7 is ignored, an index of `NUM_SRC` or above returns zero, and a zero-padded source returns its padding unchanged.
- R7: The read word is sent as four bytes, most significant first, with bit 31 first. The block releases SDA during each master ACK bit.
- R8: A master NACK ends the readout at once. The block stops driving SDA, and it also releases SDA after the fourth byte and whenever it is idle.
- R9: The block changes SDA from released to driven only after a falling SCL edge.
- R10: A write transaction that stops after the pointer byte changes the pointer and produces no write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | High: pull SDA low |
| wr_stb | output | 1 | One-cycle register write strobe |
| wr_addr | output | 8 | Register pointer for the write |
| wr_data | output | 16 | Data word for the write |
| rd_src | input | NUM_SRC*32 | Read sources, source k in bits [32k+31:32k] |

## Verification
The assertions assume a well-formed bus. SDA changes only while SCL is low, except at START and STOP. Each SCL phase lasts several system clocks, so the two-flop synchronisers show every edge. The bench master keeps to this by moving SDA only a quarter bit period after SCL falls, and by holding each phase for ten system clocks. The bench issues a START or STOP only when the slave has released SDA: after a NACK, after the last byte, or after an ACK clock.

// File: rtl/i2c_reg_slave_pkg.sv
package i2c_reg_slave_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_TXACK
  } st_e;

  typedef enum logic [2:0] {
    PH_SLV,
    PH_REG,
    PH_DHI,
    PH_DLO,
    PH_DONE
  } ph_e;

  // true when the received byte carries this slave's 7-bit address
  function automatic logic addr_hit(input logic [7:0] rx, input logic [6:0] own);
    return rx[7:1] == own;
  endfunction

  // read source index taken from the pointer
  function automatic logic [6:0] src_index(input logic [7:0] ptr);
    return ptr[6:0];
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  logic [1:0] scl_ff, sda_ff;
  logic       scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= 2'b11;
      sda_ff <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[0], scl_i};
      sda_ff <= {sda_ff[0], sda_i};
      scl_q  <= scl_ff[1];
      sda_q  <= sda_ff[1];
    end
  end

  assign scl_s     = scl_ff[1];
  assign sda_s     = sda_ff[1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign bus_start = scl_s & scl_q & sda_q & ~sda_s;
  assign bus_stop  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_read_mux.sv
module i2c_read_mux #(
  parameter int NUM_SRC = 8,
  parameter int WORD_W  = 32
) (
  input  logic [NUM_SRC*WORD_W-1:0] src,
  input  logic [6:0]                sel,
  output logic [WORD_W-1:0]         word
);
  logic [WORD_W-1:0] gated [NUM_SRC];

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign gated[g] = (sel == 7'(g)) ? src[g*WORD_W +: WORD_W] : '0;
  end

  always_comb begin
    word = '0;
    for (int k = 0; k < NUM_SRC; k++) word = word | gated[k];
  end
endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
  import i2c_reg_slave_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'h2C,
  parameter int         NUM_SRC    = 8,
  parameter int         WORD_W     = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      scl_i,
  input  logic                      sda_i,
  output logic                      sda_oe,
  output logic                      wr_stb,
  output logic [7:0]                wr_addr,
  output logic [15:0]               wr_data,
  input  logic [NUM_SRC*WORD_W-1:0] rd_src
);
  localparam int BYTES = WORD_W / 8;
  localparam int BC_W  = (BYTES > 1) ? $clog2(BYTES) : 1;

  logic scl_s, sda_s, ev_scl_rise, ev_scl_fall, ev_start, ev_stop;

  i2c_line_sync u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(ev_scl_rise), .scl_fall(ev_scl_fall),
    .bus_start(ev_start), .bus_stop(ev_stop)
  );

  st_e              st;
  ph_e              ph;
  logic [3:0]       bitcnt;
  logic [7:0]       sr, reg_ptr, dhi, dlo;
  logic             go_tx, mack, stb_q;
  logic [WORD_W-1:0] txw, rd_word;
  logic [BC_W-1:0]  bytecnt;

  i2c_read_mux #(.NUM_SRC(NUM_SRC), .WORD_W(WORD_W)) u_mux (
    .src(rd_src), .sel(src_index(reg_ptr)), .word(rd_word)
  );

  // named events for the checker
  logic ev_byte_done, ev_addr_miss;
  assign ev_byte_done = (st == ST_RX) && ev_scl_fall && (bitcnt == 4'd8);
  assign ev_addr_miss = ev_byte_done && (ph == PH_SLV) && !addr_hit(sr, SLAVE_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      ph      <= PH_SLV;
      bitcnt  <= '0;
      sr      <= '0;
      reg_ptr <= '0;
      dhi     <= '0;
      dlo     <= '0;
      go_tx   <= 1'b0;
      mack    <= 1'b0;
      stb_q   <= 1'b0;
      txw     <= '0;
      bytecnt <= '0;
    end else begin
      stb_q <= 1'b0;
      if (ev_start) begin
        st     <= ST_RX;
        ph     <= PH_SLV;
        bitcnt <= '0;
      end else if (ev_stop) begin
        st <= ST_IDLE;
      end else begin
        unique case (st)
          ST_RX: begin
            if (ev_scl_rise) begin
              sr     <= {sr[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (ev_byte_done) begin
              bitcnt <= '0;
              go_tx  <= 1'b0;
              unique case (ph)
                PH_SLV: begin
                  if (addr_hit(sr, SLAVE_ADDR)) begin
                    st    <= ST_ACK;
                    go_tx <= sr[0];
                    ph    <= PH_REG;
                  end else begin
                    st <= ST_IDLE;
                  end
                end
                PH_REG:  begin reg_ptr <= sr; st <= ST_ACK; ph <= PH_DHI;  end
                PH_DHI:  begin dhi     <= sr; st <= ST_ACK; ph <= PH_DLO;  end
                PH_DLO:  begin dlo     <= sr; st <= ST_ACK; ph <= PH_DONE; end
                default: st <= ST_IDLE;
              endcase
            end
          end
          ST_ACK: begin
            if (ev_scl_fall) begin
              if (go_tx) begin
                st      <= ST_TX;
                txw     <= rd_word;
                bytecnt <= '0;
                bitcnt  <= '0;
              end else begin
                st <= ST_RX;
                if (ph == PH_DONE) stb_q <= 1'b1;
              end
            end
          end
          ST_TX: begin
            if (ev_scl_fall) begin
              txw <= {txw[WORD_W-2:0], 1'b0};
              if (bitcnt == 4'd7) begin
                st     <= ST_TXACK;
                bitcnt <= '0;
              end else begin
                bitcnt <= bitcnt + 4'd1;
              end
            end
          end
          ST_TXACK: begin
            if (ev_scl_rise) begin
              mack <= ~sda_s;
            end else if (ev_scl_fall) begin
              if (mack && (bytecnt != BC_W'(BYTES - 1))) begin
                st      <= ST_TX;
                bytecnt <= bytecnt + 1'b1;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe  = (st == ST_ACK) || ((st == ST_TX) && !txw[WORD_W-1]);
  assign wr_stb  = stb_q;
  assign wr_addr = reg_ptr;
  assign wr_data = {dhi, dlo};
endmodule

// File: rtl/i2c_reg_slave_chk.sv
module i2c_reg_slave_chk
  import i2c_reg_slave_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input st_e        st,
  input logic [3:0] bitcnt,
  input logic       sda_oe,
  input logic       wr_stb,
  input logic       ev_start,
  input logic       ev_stop,
  input logic       ev_scl_fall,
  input logic       ev_addr_miss
);
  assert_start_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> (st == ST_RX && bitcnt == 4'd0));

  assert_stop_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop && !ev_start |=> (st == ST_IDLE));

  assert_miss_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_addr_miss |=> (st == ST_IDLE && !sda_oe));

  assert_stb_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  assert_stb_after_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> $past(st == ST_ACK));

  assert_idle_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !sda_oe);

  assert_drive_after_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(ev_scl_fall));
endmodule

bind i2c_reg_slave i2c_reg_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .st(st), .bitcnt(bitcnt), .sda_oe(sda_oe),
  .wr_stb(wr_stb), .ev_start(ev_start), .ev_stop(ev_stop),
  .ev_scl_fall(ev_scl_fall), .ev_addr_miss(ev_addr_miss)
);

// File: tb/i2c_reg_slave_tb.sv
module i2c_reg_slave_tb;
  localparam int         NSRC  = 8;
  localparam logic [6:0] SADDR = 7'h2C;
  localparam int         Q     = 10;

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, wr_stb, sda_line;
  logic [7:0]  wr_addr;
  logic [15:0] wr_data;
  logic [NSRC*32-1:0] rd_src;
  int errs = 0, checks = 0, strobes = 0;
  logic [23:0] expq[$];
  logic done = 1'b0;

  always #5 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  function automatic logic [31:0] src_val(input int i);
    if (i >= NSRC) return 32'h0;
    if (i == 2) return {16'h0000, 16'hBEEF};
    return 32'hA5000000 ^ (32'(i) * 32'h01020304);
  endfunction

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign rd_src[g*32 +: 32] = src_val(g);
  end

  i2c_reg_slave #(.SLAVE_ADDR(SADDR), .NUM_SRC(NSRC), .WORD_W(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data), .rd_src(rd_src)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard monitor for the write port
  logic prev_stb = 1'b0, prev_oe = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stb) chk("R4 strobe lasts one cycle", 32'(wr_stb), 32'h0);
      if (wr_stb) begin
        strobes++;
        if (expq.size() == 0) chk("R3 R10 no unexpected strobe", 32'h1, 32'h0);
        else chk("R4 write pointer and data", 32'({wr_addr, wr_data}), 32'(expq.pop_front()));
      end
      if (sda_oe && !prev_oe) chk("R9 SDA taken only while SCL low", 32'(scl_m), 32'h0);
      prev_stb = wr_stb;
      prev_oe  = sda_oe;
    end
  end

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic wbyte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
    end
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); acked = ~sda_line; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic rbyte(input logic give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(); scl_m = 1'b1; wq(); b[i] = sda_line; wq(); scl_m = 1'b0;
    end
    wq(); sda_m = ~give_ack; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq(); sda_m = 1'b1;
  endtask

  task automatic set_ptr(input logic [7:0] p, input logic with_stop);
    logic a;
    bus_start();
    wbyte({SADDR, 1'b0}, a); chk("R2 address ACK", 32'(a), 32'h1);
    wbyte(p, a);             chk("R5 pointer ACK", 32'(a), 32'h1);
    if (with_stop) bus_stop();
  endtask

  task automatic rd_word(input int nbytes, output logic [31:0] w);
    logic a;
    logic [7:0] b;
    bus_start();
    wbyte({SADDR, 1'b1}, a); chk("R2 read address ACK", 32'(a), 32'h1);
    w = '0;
    for (int k = 0; k < nbytes; k++) begin
      rbyte(k != nbytes - 1, b);
      w = {w[23:0], b};
    end
  endtask

  task automatic wr_reg(input logic [7:0] p, input logic [15:0] d);
    logic a;
    expq.push_back({p, d});
    set_ptr(p, 1'b0);
    wbyte(d[15:8], a); chk("R5 data high ACK", 32'(a), 32'h1);
    wbyte(d[7:0], a);  chk("R5 data low ACK", 32'(a), 32'h1);
  endtask

  initial begin
    logic a;
    logic [31:0] w;
    logic [7:0] b;
    repeat (5) @(negedge clk);
    chk("R8 reset SDA released", 32'(sda_oe), 32'h0);
    chk("R4 reset strobe low", 32'(wr_stb), 32'h0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    wr_reg(8'h10, 16'h1234); bus_stop();
    wr_reg(8'h85, 16'hCAFE);
    wbyte(8'h55, a); chk("R5 fourth byte not acked", 32'(a), 32'h0);
    bus_stop();

    // wrong address, then a matching byte without START
    bus_start();
    wbyte({SADDR ^ 7'h01, 1'b0}, a); chk("R3 mismatch not acked", 32'(a), 32'h0);
    wbyte({SADDR, 1'b0}, a);         chk("R3 ignored until START", 32'(a), 32'h0);
    wbyte(8'h20, a); wbyte(8'hAA, a); wbyte(8'hBB, a);
    chk("R3 trailing byte not acked", 32'(a), 32'h0);
    bus_stop();

    // after STOP the block is idle
    wbyte({SADDR, 1'b0}, a); chk("R1 STOP returns idle", 32'(a), 32'h0);
    bus_stop();

    set_ptr(8'h05, 1'b1);
    rd_word(4, w); chk("R6 R7 readback source 5", w, src_val(5));
    repeat (3) @(negedge clk);
    chk("R8 released after fourth byte", 32'(sda_oe), 32'h0);
    bus_stop();

    set_ptr(8'h82, 1'b1);
    rd_word(4, w); chk("R6 bit7 ignored, padded source", w, 32'h0000BEEF);
    bus_stop();

    set_ptr(8'h0A, 1'b1);
    rd_word(4, w); chk("R6 out of range reads zero", w, 32'h0);
    bus_stop();

    // pointer write then repeated START into a read
    set_ptr(8'h03, 1'b0);
    rd_word(4, w); chk("R1 repeated START read source 3", w, src_val(3));
    bus_stop();

    // early NACK
    set_ptr(8'h01, 1'b1);
    rd_word(2, w); chk("R8 two bytes before NACK", w, {16'h0, src_val(1)[31:16]});
    chk("R8 released after NACK", 32'(sda_oe), 32'h0);
    rbyte(1'b0, b); chk("R8 no drive after NACK", 32'(b), 32'hFF);
    bus_stop();

    repeat (20) @(negedge clk);
    chk("R10 strobe count", 32'(strobes), 32'h2);
    chk("R4 scoreboard drained", 32'(expq.size()), 32'h0);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errs++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule